// File: doc/BRIEF.md
# Option-Byte Program/Erase Controller

This block owns a small region of configuration double words held in a modeled non-volatile array, and lets software erase the whole region or program single 64-bit words in it. Software talks to it over a narrow register bus (key, control and status registers) and reaches the array itself over a 64-bit data bus. The data bus is used both to start a program operation and to read words back for verification.

Writes are guarded at two levels. A two-word key sequence unlocks the control register. A second two-word key sequence, accepted only once the control register is open, sets the option write enable. Erase is started from the control register. Programming is armed in the control register and then started by a data-bus write. Completion raises a sticky end flag and an optional interrupt. A program aimed at a word that is not erased is refused and flagged.

Top module: `ob_flash_ctrl`

## Requirements
- R1: After reset the control register reads locked (CTL bit 4 = 1, all other CTL bits 0), STAT reads 0, irq_o is 0 and every word of the region reads all ones.
- R2: While the control register is locked, writes to CTL (address 1) have no effect. Writing KEY_A and then KEY_B to the key register (address 0) clears CTL bit 4, after which CTL fields can be written.
- R3: With the control register unlocked, OBKEY_A and then OBKEY_B written to the key register set the write-enable status (CTL bit 5). While bit 5 is clear, erase and program requests start nothing.
- R4: Any key write that does not match the next expected key locks both levels. Further key writes then cannot unlock the block until the next reset.
- R5: Writing CTL with bit 4 set relocks both levels and clears the program-select and erase-select bits. A later correct KEY_A, KEY_B pair unlocks the control register again with bit 5 still clear.
- R6: A CTL write with erase-select (bit 1) and START (bit 2) both set, while write-enabled and idle, holds BUSY (STAT bit 0) at 1 for exactly ERASE_CYC cycles. When BUSY falls, every word reads all ones and ENDF (STAT bit 2) is set.
- R7: With program-select (CTL bit 0) set and write enabled, a data-bus write to an aligned address inside the region whose target word is all ones holds BUSY at 1 for exactly PROG_CYC cycles. When BUSY falls, the word reads back the written data and ENDF is set.
- R8: A program request to a word that is not all ones, even with all-zero data, sets PGERR (STAT bit 1) in the next cycle. The word is left unchanged, BUSY stays 0 and ENDF is not set.
- R9: While BUSY is 1, CTL writes and data-bus writes are ignored. The running operation keeps its length, and no other word or control field changes.
- R10: Writing STAT with bit 2 or bit 1 set clears ENDF or PGERR respectively.
- R11: irq_o is 1 exactly when ENDF is set and the end-interrupt enable (CTL bit 3) is set.
- R12: Data-bus writes that are misaligned, outside the region from OB_BASE to OB_BASE + 8*N_WORDS - 1, or issued while program-select is clear, change no word and no flag. Reads outside the region return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 key, 1 control, 2 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| dbus_we_i | input | 1 | Data-bus write strobe |
| dbus_addr_i | input | ADDR_W | Data-bus byte address |
| dbus_wdata_i | input | 64 | Data-bus write double word |
| dbus_rdata_o | output | 64 | Data-bus read double word (combinational) |
| irq_o | output | 1 | Completion interrupt |

## Verification
The lock state machine is the easiest thing to corrupt silently. A wrong lock state shows at once as a CTL readback that disagrees with the keys written, or as a command that starts or fails to start a BUSY period one cycle later. A corrupted cycle counter shows as a BUSY window that is shorter or longer than the configured length, so the bench times every operation against a free-running cycle count. Errors in the erased check or the write path only appear when a word is read back after BUSY falls. For that reason every operation is followed by readback of both the targeted word and an untouched neighbour.

// File: rtl/ob_pkg.sv
package ob_pkg;
  localparam int DW = 64;

  localparam logic [1:0] A_KEY  = 2'd0;
  localparam logic [1:0] A_CTL  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  // control register bit positions
  localparam int C_PG    = 0;
  localparam int C_ER    = 1;
  localparam int C_START = 2;
  localparam int C_ENDIE = 3;
  localparam int C_LOCK  = 4;
  localparam int C_WEN   = 5;

  // status register bit positions
  localparam int S_BUSY  = 0;
  localparam int S_PGERR = 1;
  localparam int S_ENDF  = 2;

  typedef enum logic [2:0] {
    LK_IDLE, LK_HALF, LK_CTL, LK_OB_HALF, LK_OB, LK_FAULT
  } lk_state_e;

  typedef enum logic [1:0] {OP_IDLE, OP_ERASE, OP_PROG} op_state_e;
endpackage

// File: rtl/ob_key_lock.sv
module ob_key_lock
  import ob_pkg::*;
#(
  parameter logic [31:0] KEY_A   = 32'h1A2B_3C4D,
  parameter logic [31:0] KEY_B   = 32'h5E6F_7081,
  parameter logic [31:0] OBKEY_A = 32'h2468_ACE0,
  parameter logic [31:0] OBKEY_B = 32'h1357_9BDF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_we_i,
  input  logic [31:0] key_i,
  input  logic        relock_i,
  output logic        ctl_unl_o,
  output logic        obwen_o
);
  lk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (relock_i && st_q != LK_FAULT) begin
      st_d = LK_IDLE;
    end else if (key_we_i) begin
      unique case (st_q)
        LK_IDLE:    st_d = (key_i == KEY_A)   ? LK_HALF    : LK_FAULT;
        LK_HALF:    st_d = (key_i == KEY_B)   ? LK_CTL     : LK_FAULT;
        LK_CTL:     st_d = (key_i == OBKEY_A) ? LK_OB_HALF : LK_FAULT;
        LK_OB_HALF: st_d = (key_i == OBKEY_B) ? LK_OB      : LK_FAULT;
        LK_OB:      st_d = LK_OB;
        default:    st_d = LK_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LK_IDLE;
    else         st_q <= st_d;
  end

  assign ctl_unl_o = (st_q == LK_CTL) || (st_q == LK_OB_HALF) || (st_q == LK_OB);
  assign obwen_o   = (st_q == LK_OB);

  p_unlock_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_unl_o) |-> $past(key_we_i && key_i == KEY_B));

  p_fault_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_FAULT) |=> (st_q == LK_FAULT) && !ctl_unl_o && !obwen_o);

  p_relock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_i |=> !ctl_unl_o && !obwen_o);
endmodule

// File: rtl/ob_op_seq.sv
module ob_op_seq
  import ob_pkg::*;
#(
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 16,
  parameter int IDX_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_go_i,
  input  logic             prog_go_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [DW-1:0]    prog_data_i,
  input  logic             pg_fail_i,
  input  logic             clr_endf_i,
  input  logic             clr_pgerr_i,
  output logic             busy_o,
  output logic             endf_o,
  output logic             pgerr_o,
  output logic             erase_done_o,
  output logic             prog_done_o,
  output logic [IDX_W-1:0] done_idx_o,
  output logic [DW-1:0]    done_data_o
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  op_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= OP_IDLE;
      cnt_q       <= '0;
      done_idx_o  <= '0;
      done_data_o <= '0;
    end else if (st_q == OP_IDLE) begin
      if (erase_go_i) begin
        st_q  <= OP_ERASE;
        cnt_q <= CNT_W'(ERASE_CYC - 1);
      end else if (prog_go_i) begin
        st_q        <= OP_PROG;
        cnt_q       <= CNT_W'(PROG_CYC - 1);
        done_idx_o  <= prog_idx_i;
        done_data_o <= prog_data_i;
      end
    end else if (cnt_q == '0) begin
      st_q <= OP_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o       = (st_q != OP_IDLE);
  assign erase_done_o = (st_q == OP_ERASE) && (cnt_q == '0);
  assign prog_done_o  = (st_q == OP_PROG)  && (cnt_q == '0);

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      endf_o  <= 1'b0;
      pgerr_o <= 1'b0;
    end else begin
      if (erase_done_o || prog_done_o) endf_o <= 1'b1;
      else if (clr_endf_i)             endf_o <= 1'b0;
      if (pg_fail_i)                   pgerr_o <= 1'b1;
      else if (clr_pgerr_i)            pgerr_o <= 1'b0;
    end
  end

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != OP_IDLE && cnt_q != '0) |=> (st_q == $past(st_q)) && (cnt_q == $past(cnt_q) - 1'b1));

  p_endf_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(endf_o) |-> $past(busy_o));

  p_pgerr_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgerr_o) |-> $past(!busy_o) && !busy_o);
endmodule

// File: rtl/ob_store.sv
module ob_store
  import ob_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_erased_o
);
  logic [DW-1:0] mem_q [N_WORDS];

  // modeled as delivered erased
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WORDS; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < N_WORDS; i++) mem_q[i] <= '1;
    end else if (wr_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o   = mem_q[rd_idx_i];
  assign rd_erased_o = &mem_q[rd_idx_i];

  p_erase_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (&mem_q[0]) && (&mem_q[N_WORDS-1]));

  p_prog_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !erase_i) |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/ob_flash_ctrl.sv
module ob_flash_ctrl
  import ob_pkg::*;
#(
  parameter int              N_WORDS   = 4,
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     OB_BASE   = 16'h0800,
  parameter int              ERASE_CYC = 64,
  parameter int              PROG_CYC  = 16,
  parameter logic [31:0]     KEY_A     = 32'h1A2B_3C4D,
  parameter logic [31:0]     KEY_B     = 32'h5E6F_7081,
  parameter logic [31:0]     OBKEY_A   = 32'h2468_ACE0,
  parameter logic [31:0]     OBKEY_B   = 32'h1357_9BDF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              dbus_we_i,
  input  logic [ADDR_W-1:0] dbus_addr_i,
  input  logic [63:0]       dbus_wdata_i,
  output logic [63:0]       dbus_rdata_o,
  output logic              irq_o
);
  localparam int IDX_W     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int REG_BYTES = N_WORDS * 8;

  logic ctl_unl, obwen, busy, endf, pgerr;
  logic pg_q, er_q, endie_q;
  logic erase_done, prog_done;
  logic [IDX_W-1:0] done_idx;
  logic [DW-1:0]    done_data, rd_word;
  logic             rd_erased;

  // data-bus decode
  logic [ADDR_W-1:0] off;
  logic              in_reg;
  logic [IDX_W-1:0]  idx;
  assign off    = dbus_addr_i - ADDR_W'(OB_BASE);
  assign in_reg = (dbus_addr_i >= ADDR_W'(OB_BASE)) && (off < ADDR_W'(REG_BYTES))
                  && (off[2:0] == 3'b000);
  assign idx    = off[IDX_W+2:3];

  // register-bus decode
  logic key_we, ctl_we, relock, erase_go, prog_try, prog_go, pg_fail;
  logic clr_endf, clr_pgerr;
  assign key_we    = reg_we_i && (reg_addr_i == A_KEY);
  assign ctl_we    = reg_we_i && (reg_addr_i == A_CTL) && ctl_unl && !busy;
  assign relock    = ctl_we && reg_wdata_i[C_LOCK];
  assign erase_go  = ctl_we && !reg_wdata_i[C_LOCK] && obwen
                     && reg_wdata_i[C_ER] && reg_wdata_i[C_START];
  assign prog_try  = dbus_we_i && in_reg && pg_q && obwen && !busy;
  assign prog_go   = prog_try && rd_erased;
  assign pg_fail   = prog_try && !rd_erased;
  assign clr_endf  = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[S_ENDF];
  assign clr_pgerr = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[S_PGERR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q    <= 1'b0;
      er_q    <= 1'b0;
      endie_q <= 1'b0;
    end else if (relock) begin
      pg_q <= 1'b0;
      er_q <= 1'b0;
    end else if (ctl_we) begin
      pg_q    <= reg_wdata_i[C_PG];
      er_q    <= reg_wdata_i[C_ER];
      endie_q <= reg_wdata_i[C_ENDIE];
    end
  end

  ob_key_lock #(
    .KEY_A(KEY_A), .KEY_B(KEY_B), .OBKEY_A(OBKEY_A), .OBKEY_B(OBKEY_B)
  ) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_we_i(key_we), .key_i(reg_wdata_i),
    .relock_i(relock), .ctl_unl_o(ctl_unl), .obwen_o(obwen)
  );

  ob_op_seq #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .IDX_W(IDX_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .erase_go_i(erase_go), .prog_go_i(prog_go),
    .prog_idx_i(idx), .prog_data_i(dbus_wdata_i), .pg_fail_i(pg_fail),
    .clr_endf_i(clr_endf), .clr_pgerr_i(clr_pgerr), .busy_o(busy),
    .endf_o(endf), .pgerr_o(pgerr), .erase_done_o(erase_done),
    .prog_done_o(prog_done), .done_idx_o(done_idx), .done_data_o(done_data)
  );

  ob_store #(
    .N_WORDS(N_WORDS), .IDX_W(IDX_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .erase_i(erase_done), .wr_i(prog_done),
    .wr_idx_i(done_idx), .wr_data_i(done_data), .rd_idx_i(idx),
    .rd_data_o(rd_word), .rd_erased_o(rd_erased)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTL: begin
        reg_rdata_o[C_PG]    = pg_q;
        reg_rdata_o[C_ER]    = er_q;
        reg_rdata_o[C_ENDIE] = endie_q;
        reg_rdata_o[C_LOCK]  = !ctl_unl;
        reg_rdata_o[C_WEN]   = obwen;
      end
      A_STAT: begin
        reg_rdata_o[S_BUSY]  = busy;
        reg_rdata_o[S_PGERR] = pgerr;
        reg_rdata_o[S_ENDF]  = endf;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign dbus_rdata_o = in_reg ? rd_word : '0;
  assign irq_o        = endf && endie_q;

  p_go_needs_wen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(obwen));

  p_relock_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock |=> !pg_q && !er_q);

  p_locked_ctl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_unl |=> $stable(endie_q) || $past(ctl_unl));
endmodule

// File: tb/sim_ob_flash_ctrl.sv
module sim_ob_flash_ctrl;
  localparam logic [15:0] BASE   = 16'h0800;
  localparam logic [31:0] K_A    = 32'h1A2B_3C4D;
  localparam logic [31:0] K_B    = 32'h5E6F_7081;
  localparam logic [31:0] OK_A   = 32'h2468_ACE0;
  localparam logic [31:0] OK_B   = 32'h1357_9BDF;
  localparam int          T_ER   = 64;
  localparam int          T_PG   = 16;
  localparam logic [63:0] ONES   = '1;
  localparam logic [63:0] D1     = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] D2     = 64'hFEDC_0000_1111_2222;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbus_we = 1'b0;
  logic [15:0] dbus_addr = BASE;
  logic [63:0] dbus_wdata = '0;
  logic [63:0] dbus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ob_flash_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dbus_we_i(dbus_we),
    .dbus_addr_i(dbus_addr), .dbus_wdata_i(dbus_wdata), .dbus_rdata_o(dbus_rdata),
    .irq_o(irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic db_wr(logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    dbus_we = 1'b1; dbus_addr = a; dbus_wdata = d;
    @(negedge clk);
    dbus_we = 1'b0;
  endtask

  task automatic db_rd(logic [15:0] a, output logic [63:0] d);
    dbus_addr = a; #1; d = dbus_rdata;
  endtask

  task automatic wait_idle(output int dur);
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      reg_rd(2'd2, s);
      if (!s[0]) break;
      @(negedge clk);
    end
    dur = cyc - t0;
  endtask

  task automatic t_reset();
    logic [31:0] r; logic [63:0] w;
    reg_rd(2'd1, r); check("R1 ctl", 64'(r), 64'h10);
    reg_rd(2'd2, r); check("R1 stat", 64'(r), 64'h0);
    check("R1 irq", 64'(irq), 64'h0);
    db_rd(BASE, w); check("R1 word0", w, ONES);
    db_rd(BASE + 16'd24, w); check("R1 word3", w, ONES);
  endtask

  task automatic t_unlock();
    logic [31:0] r;
    reg_wr(2'd1, 32'h08);
    reg_rd(2'd1, r); check("R2 locked write ignored", 64'(r), 64'h10);
    reg_wr(2'd0, K_A);
    reg_wr(2'd0, K_B);
    reg_rd(2'd1, r); check("R2 unlocked", 64'(r), 64'h00);
    reg_wr(2'd1, 32'h08);
    reg_rd(2'd1, r); check("R2 ctl writable", 64'(r), 64'h08);
  endtask

  task automatic t_wen();
    logic [31:0] r; logic [63:0] w;
    reg_wr(2'd1, 32'h0E);
    reg_rd(2'd2, r); check("R3 erase without wen", 64'(r), 64'h0);
    reg_wr(2'd1, 32'h09);
    db_wr(BASE, 64'h0);
    reg_rd(2'd2, r); check("R3 program without wen stat", 64'(r), 64'h0);
    db_rd(BASE, w); check("R3 program without wen word", w, ONES);
    reg_wr(2'd0, OK_A);
    reg_wr(2'd0, OK_B);
    reg_rd(2'd1, r); check("R3 wen set", 64'(r), 64'h29);
  endtask

  task automatic t_program();
    logic [31:0] r; logic [63:0] w; int dur;
    db_wr(BASE + 16'd8, D1);
    t0 = cyc;
    reg_rd(2'd2, r); check("R7 busy after write", 64'(r[0]), 64'h1);
    db_wr(BASE + 16'd16, D2);
    reg_wr(2'd1, 32'h0E);
    wait_idle(dur);
    check("R9 program length kept", 64'(dur), 64'(T_PG));
    db_rd(BASE + 16'd8, w); check("R7 word1 programmed", w, D1);
    db_rd(BASE + 16'd16, w); check("R9 word2 untouched", w, ONES);
    reg_rd(2'd2, r); check("R7 endf", 64'(r), 64'h4);
    reg_rd(2'd1, r); check("R9 ctl unchanged", 64'(r), 64'h29);
    check("R11 irq on", 64'(irq), 64'h1);
    reg_wr(2'd2, 32'h4);
    reg_rd(2'd2, r); check("R10 endf cleared", 64'(r), 64'h0);
    check("R11 irq off", 64'(irq), 64'h0);
  endtask

  task automatic t_pgerr();
    logic [31:0] r; logic [63:0] w;
    db_wr(BASE + 16'd8, 64'h0);
    reg_rd(2'd2, r); check("R8 pgerr set no busy no endf", 64'(r), 64'h2);
    db_rd(BASE + 16'd8, w); check("R8 word1 unchanged", w, D1);
    check("R8 irq stays low", 64'(irq), 64'h0);
    reg_wr(2'd2, 32'h2);
    reg_rd(2'd2, r); check("R10 pgerr cleared", 64'(r), 64'h0);
  endtask

  task automatic t_region();
    logic [31:0] r; logic [63:0] w;
    db_wr(BASE + 16'd28, D2);
    db_rd(BASE + 16'd24, w); check("R12 misaligned", w, ONES);
    reg_rd(2'd2, r); check("R12 misaligned stat", 64'(r), 64'h0);
    db_wr(BASE - 16'd8, D2);
    db_wr(BASE + 16'd32, D2);
    reg_rd(2'd2, r); check("R12 outside stat", 64'(r), 64'h0);
    db_rd(BASE + 16'd32, w); check("R12 outside read", w, 64'h0);
    reg_wr(2'd1, 32'h08);
    db_wr(BASE + 16'd24, D2);
    db_rd(BASE + 16'd24, w); check("R12 pg clear", w, ONES);
    reg_rd(2'd2, r); check("R12 pg clear stat", 64'(r), 64'h0);
  endtask

  task automatic t_erase();
    logic [31:0] r; logic [63:0] w; int dur;
    reg_wr(2'd1, 32'h0E);
    t0 = cyc;
    wait_idle(dur);
    check("R6 erase length", 64'(dur), 64'(T_ER));
    db_rd(BASE + 16'd8, w); check("R6 word1 erased", w, ONES);
    reg_rd(2'd2, r); check("R6 endf", 64'(r), 64'h4);
    check("R11 irq after erase", 64'(irq), 64'h1);
    reg_wr(2'd1, 32'h00);
    check("R11 irq masked", 64'(irq), 64'h0);
    reg_wr(2'd2, 32'h4);
  endtask

  task automatic t_relock();
    logic [31:0] r;
    reg_wr(2'd1, 32'h10);
    reg_rd(2'd1, r); check("R5 relocked", 64'(r), 64'h10);
    reg_wr(2'd1, 32'h0E);
    reg_rd(2'd2, r); check("R5 erase refused", 64'(r), 64'h0);
    reg_wr(2'd0, K_A);
    reg_wr(2'd0, K_B);
    reg_rd(2'd1, r); check("R5 wen stays clear", 64'(r), 64'h00);
  endtask

  task automatic t_fault();
    logic [31:0] r;
    reg_wr(2'd0, 32'hDEAD_BEEF);
    reg_rd(2'd1, r); check("R4 wrong key locks", 64'(r), 64'h10);
    reg_wr(2'd0, K_A);
    reg_wr(2'd0, K_B);
    reg_rd(2'd1, r); check("R4 stays locked", 64'(r), 64'h10);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reg_wr(2'd0, K_A);
    reg_wr(2'd0, K_B);
    reg_rd(2'd1, r); check("R4 reset recovers", 64'(r), 64'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlock();
    t_wen();
    t_program();
    t_pgerr();
    t_region();
    t_erase();
    t_relock();
    t_fault();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule